// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single 16-bit timer channel. A reload value and a counting mode are written together through a one-cycle load strobe. After that, the channel counts down on a clock-enable tick. A gate input enables counting or retriggers it, depending on the mode. The channel drives a live count and one output pin.

Six behaviours are available:
- an event at terminal count;
- a gate-triggered one-shot;
- a periodic rate generator;
- a square-wave generator that steps the count by two;
- a strobe started by a load;
- a strobe started by the gate.

A reload value of zero stands for 65536. An output-enable input masks the pin without disturbing the count, so the pin shows the true level again as soon as the enable returns. Byte sequencing and bus decoding sit outside the block. Counting is binary only.

Top module: `timer_channel`

## Requirements
- R1: After reset the count is 0, the internal output level is high (outPin high with outEn high), and the stored mode is 0.
- R2: A cycle with loadStb high stores loadVal as the reload value and the folded modeSel as the mode. The count equals loadVal after that edge. A load outranks a tick and a gate rising edge in the same cycle.
- R3: A reload value of 0 acts as 65536 counts. In modes 0, 1, 4 and 5 the count keeps decrementing past 0 and wraps to 0xFFFF.
- R4: Mode 0 (value 0): the output goes low at load and goes high on the tick that takes the count from 1 to 0, which is N ticks after a load of N. It then stays high.
- R5: Mode 1 (value 1): the output stays high at load. A gate rising edge reloads the count and drives the output low. The output goes high again on the tick where the count reaches 0. A new rising edge mid-count restarts the count.
- R6: Mode 2 (value 2): the count runs N, N-1 ... 1 and then reloads N, giving a period of N ticks (N of at least 2). The output is low only while the count is 1.
- R7: Mode 3 (value 3): the count drops by two per tick. The count reloads and the output toggles once every ceil(N/2) ticks, starting high after load.
- R8: Mode 4 (value 4): the output stays high after load. It is low for exactly one tick interval after the count reaches 0, and this happens only once per load.
- R9: Mode 5 (value 5): like mode 4, but it is armed by a gate rising edge that also reloads the count. It gives one low interval per trigger.
- R10: In modes 0, 2, 3 and 4 a low gate holds the count, and in modes 2 and 3 it also forces the output high. In modes 1 and 5 the count runs regardless of the gate. A gate rising edge reloads the count in modes 1, 2, 3 and 5 and takes the place of that cycle's tick. In modes 0 and 4 a rising edge has no effect beyond enabling counting.
- R11: With outEn low, outPin is low while the count advances normally. Raising outEn shows the current level immediately.
- R12: Mode values 6 and 7 behave as modes 2 and 3.
- R13: With tick low and no load or gate trigger, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one count per cycle it is high |
| loadStb | input | 1 | Load strobe for loadVal and modeSel |
| loadVal | input | 16 | Reload value, 0 means 65536 |
| modeSel | input | 3 | Counting mode captured at load |
| gateIn | input | 1 | Gate: level enable or rising-edge trigger |
| outEn | input | 1 | Output enable, masks outPin to low |
| count | output | 16 | Live count |
| outPin | output | 1 | Channel output after masking |

## Verification
Several events can land on the same clock edge:
- a load together with a tick;
- a load together with a gate rising edge;
- a gate rising edge together with a tick, in the retriggering modes.

The bench provokes each of these by changing the gate and strobing the load on one falling edge while tick is held high. It judges the result by the count one edge later: the loaded or reload value must appear undecremented, and the following tick must resume the normal decrement. Expected counts and output levels in the sweeps are computed from the reload value and the tick index alone.

// File: rtl/timer_channel_pkg.sv
package timer_channel_pkg;

  typedef enum logic [2:0] {
    MODE_TC_EVENT  = 3'd0,
    MODE_ONE_SHOT  = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } mode_e;

  typedef struct packed {
    logic load;
    logic restart;
    logic stepOne;
    logic stepTwo;
    logic reloadNow;
  } dpStrobe_t;

  // Values 6 and 7 alias the periodic modes 2 and 3.
  function automatic mode_e foldMode(input logic [2:0] raw);
    if (raw[2] && raw[1]) return mode_e'({1'b0, raw[1:0]});
    return mode_e'(raw);
  endfunction

endpackage

// File: rtl/timer_channel_dp.sv
module timer_channel_dp
  import timer_channel_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       stb,
  input  logic [CntW-1:0] loadVal,
  output logic [CntW-1:0] countQ,
  output logic            isOne,
  output logic            isTwo
);

  localparam logic [CntW-1:0] One = CntW'(1);
  localparam logic [CntW-1:0] Two = CntW'(2);

  logic [CntW-1:0] reloadQ;
  logic [CntW-1:0] countD;

  always_comb begin
    countD = countQ;
    if (stb.load)           countD = loadVal;
    else if (stb.restart)   countD = reloadQ;
    else if (stb.reloadNow) countD = reloadQ;
    else if (stb.stepTwo)   countD = countQ - Two;
    else if (stb.stepOne)   countD = countQ - One;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      reloadQ <= '0;
    end else begin
      countQ <= countD;
      if (stb.load) reloadQ <= loadVal;
    end
  end

  assign isOne = (countQ == One);
  assign isTwo = (countQ == Two);

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> countQ == $past(loadVal));

  p_restart_reload_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restart && !stb.load) |=> countQ == $past(reloadQ));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> $stable(countQ));

  p_square_parity_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepTwo && !stb.load && !stb.restart) |=> countQ[0] == $past(countQ[0]));

endmodule

// File: rtl/timer_channel_ctrl.sv
module timer_channel_ctrl
  import timer_channel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       loadStb,
  input  logic [2:0] modeSel,
  input  logic       gateIn,
  input  logic       isOne,
  input  logic       isTwo,
  output dpStrobe_t  stb,
  output logic       outLvl
);

  mode_e modeQ;
  mode_e modeNew;
  logic  gatePrev;
  logic  armedQ;
  logic  outQ;
  logic  gateRise;
  logic  retrigMode;
  logic  freeRun;
  logic  countEn;
  logic  periodic;

  assign modeNew    = foldMode(modeSel);
  assign gateRise   = gateIn && !gatePrev;
  assign retrigMode = modeQ inside {MODE_ONE_SHOT, MODE_RATE, MODE_SQUARE, MODE_HW_STROBE};
  assign freeRun    = modeQ inside {MODE_ONE_SHOT, MODE_HW_STROBE};
  assign periodic   = modeQ inside {MODE_RATE, MODE_SQUARE};

  always_comb begin
    stb         = '0;
    stb.load    = loadStb;
    stb.restart = !loadStb && gateRise && retrigMode;
    countEn     = tick && !loadStb && !stb.restart && (gateIn || freeRun);
    if (modeQ == MODE_SQUARE) begin
      stb.reloadNow = countEn && (isOne || isTwo);
      stb.stepTwo   = countEn && !(isOne || isTwo);
    end else if (modeQ == MODE_RATE) begin
      stb.reloadNow = countEn && isOne;
      stb.stepOne   = countEn && !isOne;
    end else begin
      stb.stepOne   = countEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_TC_EVENT;
      gatePrev <= 1'b0;
      armedQ   <= 1'b0;
      outQ     <= 1'b1;
    end else begin
      gatePrev <= gateIn;
      if (loadStb) begin
        modeQ  <= modeNew;
        outQ   <= (modeNew != MODE_TC_EVENT);
        armedQ <= (modeNew inside {MODE_TC_EVENT, MODE_SW_STROBE});
      end else if (stb.restart) begin
        armedQ <= 1'b1;
        outQ   <= (modeQ != MODE_ONE_SHOT);
      end else if (!gateIn && periodic) begin
        outQ <= 1'b1;
      end else if (countEn) begin
        unique case (modeQ)
          MODE_TC_EVENT, MODE_ONE_SHOT: begin
            if (armedQ && isOne) begin
              outQ   <= 1'b1;
              armedQ <= 1'b0;
            end
          end
          MODE_SW_STROBE, MODE_HW_STROBE: begin
            if (armedQ && isOne) begin
              outQ   <= 1'b0;
              armedQ <= 1'b0;
            end else begin
              outQ <= 1'b1;
            end
          end
          MODE_RATE:   outQ <= !isTwo;
          MODE_SQUARE: if (isOne || isTwo) outQ <= !outQ;
          default:     outQ <= outQ;
        endcase
      end
    end
  end

  assign outLvl = outQ;

  p_load_mode0_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && modeNew == MODE_TC_EVENT) |=> !outQ);

  p_trigger_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ONE_SHOT && stb.restart) |=> !outQ);

  p_rate_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_RATE && !outQ && tick && gateIn && !loadStb) |=> outQ);

  p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_HW_STROBE && !outQ && tick && !loadStb) |=> outQ);

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_channel_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            loadStb,
  input  logic [CntW-1:0] loadVal,
  input  logic [2:0]      modeSel,
  input  logic            gateIn,
  input  logic            outEn,
  output logic [CntW-1:0] count,
  output logic            outPin
);

  dpStrobe_t stb;
  logic      isOne;
  logic      isTwo;
  logic      outLvl;

  timer_channel_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .loadStb (loadStb),
    .modeSel (modeSel),
    .gateIn  (gateIn),
    .isOne   (isOne),
    .isTwo   (isTwo),
    .stb     (stb),
    .outLvl  (outLvl)
  );

  timer_channel_dp #(.CntW(CntW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .loadVal (loadVal),
    .countQ  (count),
    .isOne   (isOne),
    .isTwo   (isTwo)
  );

  // R11: masking sits after the level register, so counting is untouched.
  assign outPin = outLvl && outEn;

endmodule

// File: tb/timer_channel_bench.sv
module timer_channel_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        loadStb = 1'b0;
  logic [15:0] loadVal = '0;
  logic [2:0]  modeSel = '0;
  logic        gateIn = 1'b0;
  logic        outEn = 1'b1;
  logic [15:0] count;
  logic        outPin;

  int nChecks = 0;
  int nErrs = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  timer_channel u_timer_channel (
    .clk(clk), .rstN(rstN), .tick(tick), .loadStb(loadStb), .loadVal(loadVal),
    .modeSel(modeSel), .gateIn(gateIn), .outEn(outEn), .count(count), .outPin(outPin)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadCh(input logic [2:0] m, input logic [15:0] v);
    loadStb = 1'b1;
    modeSel = m;
    loadVal = v;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic expect2(input string req, input int c, input int o);
    check(req, "count", int'(count), c);
    check(req, "outPin", int'(outPin), o);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    ticks(3);
    rstN = 1'b1;
    ticks(1);
    expect2("R1", 0, 1);
    ticks(5);
    check("R13", "count idle", int'(count), 0);
    tick = 1'b1;
    ticks(3);
    check("R10 gate low mode0", "count", int'(count), 0);

    // Mode 0 sweep
    gateIn = 1'b1;
    ticks(1);
    for (int n = 1; n <= 20; n++) begin
      loadCh(3'd0, 16'(n));
      expect2("R2 R4 load", n, 0);
      ticks(n - 1);
      expect2("R4 before tc", 1, 0);
      ticks(1);
      expect2("R4 at tc", 0, 1);
      ticks(1);
      expect2("R3 wrap", 65535, 1);
    end

    // Mode 0 gate hold and rising edge ignored
    loadCh(3'd0, 16'd10);
    gateIn = 1'b0;
    ticks(5);
    expect2("R10 mode0 hold", 10, 0);
    gateIn = 1'b1;
    ticks(1);
    expect2("R10 mode0 rise ignored", 9, 0);
    ticks(8);
    expect2("R4 after hold", 1, 0);
    ticks(1);
    expect2("R4 after hold tc", 0, 1);

    // Reload mid-count
    loadCh(3'd0, 16'd50);
    ticks(10);
    loadCh(3'd0, 16'd7);
    expect2("R2 reload mid-count", 7, 0);

    // Zero reload means 65536
    loadCh(3'd0, 16'd0);
    ticks(65535);
    expect2("R3 zero reload before tc", 1, 0);
    ticks(1);
    expect2("R3 zero reload tc", 0, 1);
    ticks(1);
    expect2("R3 wrap after zero", 65535, 1);

    // Mode 2 sweep
    for (int n = 2; n <= 12; n++) begin
      loadCh(3'd2, 16'(n));
      expect2("R6 load", n, 1);
      for (int k = 1; k <= 2 * n; k++) begin
        int ec;
        ticks(1);
        ec = ((k % n) == 0) ? n : n - (k % n);
        expect2("R6 sweep", ec, (ec != 1) ? 1 : 0);
      end
    end

    // Mode 3 sweep
    for (int n = 1; n <= 13; n++) begin
      int half;
      half = (n + 1) / 2;
      loadCh(3'd3, 16'(n));
      expect2("R7 load", n, 1);
      for (int k = 1; k <= 2 * n + 2; k++) begin
        ticks(1);
        expect2("R7 sweep", n - 2 * (k % half), (((k / half) % 2) == 0) ? 1 : 0);
      end
    end

    // Mode 3 gate low, then gate restart
    loadCh(3'd3, 16'd8);
    ticks(5);
    expect2("R7 mid", 6, 0);
    gateIn = 1'b0;
    ticks(1);
    expect2("R10 mode3 gate low forces high", 6, 1);
    ticks(3);
    check("R10 mode3 hold", "count", int'(count), 6);
    gateIn = 1'b1;
    ticks(1);
    expect2("R10 mode3 restart", 8, 1);
    ticks(4);
    expect2("R7 after restart", 8, 0);

    // Aliases
    loadCh(3'd6, 16'd4);
    ticks(3);
    expect2("R12 mode6 as rate", 1, 0);
    loadCh(3'd7, 16'd6);
    ticks(3);
    expect2("R12 mode7 as square", 6, 0);

    // Mode 2 retrigger and same-cycle collisions
    loadCh(3'd2, 16'd10);
    ticks(4);
    check("R6 count", "count", int'(count), 6);
    gateIn = 1'b0;
    ticks(2);
    expect2("R10 mode2 hold", 6, 1);
    gateIn = 1'b1;
    ticks(1);
    check("R10 rise beats tick", "count", int'(count), 10);
    gateIn = 1'b0;
    ticks(1);
    gateIn = 1'b1;
    loadCh(3'd2, 16'd20);
    check("R2 load beats rise and tick", "count", int'(count), 20);
    ticks(1);
    check("R2 resume after collision", "count", int'(count), 19);

    // Mode 1
    gateIn = 1'b0;
    loadCh(3'd1, 16'd6);
    expect2("R5 load", 6, 1);
    ticks(3);
    expect2("R10 mode1 free-run", 3, 1);
    gateIn = 1'b1;
    ticks(1);
    expect2("R5 trigger", 6, 0);
    ticks(5);
    expect2("R5 before tc", 1, 0);
    ticks(1);
    expect2("R5 tc", 0, 1);
    gateIn = 1'b0;
    ticks(1);
    check("R3 mode1 wrap", "count", int'(count), 65535);
    gateIn = 1'b1;
    ticks(1);
    expect2("R5 second trigger", 6, 0);
    ticks(2);
    gateIn = 1'b0;
    ticks(1);
    gateIn = 1'b1;
    ticks(1);
    expect2("R5 retrigger mid-count", 6, 0);
    ticks(6);
    expect2("R5 retrigger tc", 0, 1);

    // Mode 5
    gateIn = 1'b0;
    loadCh(3'd5, 16'd5);
    ticks(2);
    expect2("R9 unarmed", 3, 1);
    gateIn = 1'b1;
    ticks(1);
    expect2("R9 trigger", 5, 1);
    ticks(4);
    expect2("R9 before strobe", 1, 1);
    ticks(1);
    expect2("R9 strobe", 0, 0);
    ticks(1);
    expect2("R9 strobe end", 65535, 1);
    ticks(65534);
    expect2("R9 single strobe", 1, 1);
    ticks(1);
    expect2("R9 no second strobe", 0, 1);

    // Mode 4
    loadCh(3'd4, 16'd4);
    expect2("R8 load", 4, 1);
    ticks(3);
    expect2("R8 before strobe", 1, 1);
    ticks(1);
    expect2("R8 strobe", 0, 0);
    ticks(1);
    expect2("R8 strobe end", 65535, 1);
    loadCh(3'd4, 16'd9);
    ticks(2);
    gateIn = 1'b0;
    ticks(1);
    check("R10 mode4 hold", "count", int'(count), 7);
    gateIn = 1'b1;
    ticks(1);
    check("R10 mode4 rise ignored", "count", int'(count), 6);

    // Output enable
    loadCh(3'd2, 16'd5);
    outEn = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      int ec;
      ticks(1);
      ec = ((k % 5) == 0) ? 5 : 5 - (k % 5);
      expect2("R11 masked", ec, 0);
    end
    outEn = 1'b1;
    #1;
    check("R11 unmask", "outPin", int'(outPin), 1);
    ticks(4);
    expect2("R11 true level", 1, 0);

    // Tick low
    tick = 1'b0;
    loadCh(3'd2, 16'd5);
    ticks(5);
    expect2("R13 no tick", 5, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

endmodule